// File: doc/BRIEF.md
# Lockable 16-Pin GPIO Port

This block is one general-purpose I/O port of sixteen pins. Software reaches it through a plain register bus that has a word address, a write strobe with write data, and a read strobe. Read data comes back registered, one cycle after the read strobe. The bus has no handshake: every strobe completes in the cycle it is raised.

Each pin has a 4-bit configuration field and a speed-boost bit. The field picks input, or output at one of three speed grades, and with it push-pull, open-drain, floating or pulled input. The output data word can be written whole, or changed bit by bit through a set register and a clear register. Pin levels reach the input status register through a two-flop synchronizer. The pad drive is computed from configuration and output data: an output value, an output enable, and pull-up and pull-down selects. For a pulled input, the output data bit chooses the pull direction.

The configuration of chosen pins can be frozen until the next reset. A lock register holds a 16-bit pin mask and a key bit. The lock takes effect only after an exact five-access key sequence on that register. Locking freezes configuration only; output data stays writable.

Top module: `gpio_lockport`

## Requirements
- R1: After reset every configuration field is 4'h4 (floating input), output data, speed-boost bits, lock mask and key are 0, and all output enables and pull selects are low.
- R2: Pin i's configuration field sits at bits 4*(i%8)+3:4*(i%8) of CFG_LO (address 0) for pins 0-7 and of CFG_HI (address 1) for pins 8-15, and reads back as written. The speed-boost register (address 6) holds one bit per pin in bits 15:0 and reads 0 in bits 31:16.
- R3: A write to SET (address 4) ORs write data bits 15:0 into the output data. A write to CLR (address 5) clears the output data bits where write data bits 15:0 are 1. Other bits keep their value.
- R4: A write to OUT (address 3) loads output data from bits 15:0, and a read of OUT returns it. Reads of SET and CLR return 0. Read data appears on the cycle after the read strobe.
- R5: A field whose bits 1:0 are non-zero makes the pin an output. If bit 2 is 0 (push-pull), the output enable is 1 and the pin drives its output data bit. If bit 2 is 1 (open-drain), the pin drives 0 with the enable high only while its output data bit is 0. A field with bits 1:0 equal to 0 is an input with the output enable low.
- R6: A field with bits 1:0 = 00 and bits 3:2 = 10 is a pulled input. Its output data bit 1 raises the pull-up select and 0 raises the pull-down select. No other field raises either select.
- R7: The input status register (address 2) returns pad levels through two flops. A read strobe in the cycle a pad changes, and in the next cycle, still returns the old level. A read strobe two cycles after the change returns the new level.
- R8: The lock register (address 7) has the pin mask in bits 15:0 and the key in bit 16. The lock commits only after these five accesses in order: write key=1, write key=0, write key=1, all three with the same mask, then a read that returns key 0, then a read that returns key 1.
- R9: Once locked, writes to the configuration fields and speed-boost bits of masked pins have no effect, while unmasked pins, OUT, SET and CLR stay writable.
- R10: A lock-register access out of order, or a mask change between writes, returns the sequence to idle without locking. From idle, a write with key=1 starts a new sequence.
- R11: After the lock commits, the key reads 1 and the mask is frozen until reset; further lock sequences change nothing.
- R12: Accesses to other registers between the steps of a lock sequence do not disturb it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register word address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 16 | Pin levels from the pads |
| pad_out | output | 16 | Pin output values |
| pad_oe | output | 16 | Pin output enables |
| pad_pu | output | 16 | Pull-up selects |
| pad_pd | output | 16 | Pull-down selects |

## Verification
The hardest state to reach from the ports is the one just before the lock commits. Getting there takes five lock-register accesses in order, and the key must read 0 and then 1. The stimulus drives a full sequence with writes and reads to other registers mixed in between the steps. It then checks that configuration writes to masked pins are refused, while output data and unmasked pins still change. Near-miss sequences, one with the mask changed partway and one with a fourth write where a read belongs, must leave every field writable. A later attempt to lock more pins must leave the committed mask as it was.

// File: rtl/gpl_pkg.sv
package gpl_pkg;
  typedef enum logic [2:0] {
    ADR_CFGL  = 3'd0,
    ADR_CFGH  = 3'd1,
    ADR_IN    = 3'd2,
    ADR_OUT   = 3'd3,
    ADR_SET   = 3'd4,
    ADR_CLR   = 3'd5,
    ADR_BOOST = 3'd6,
    ADR_LOCK  = 3'd7
  } gpl_addr_e;

  typedef enum logic [2:0] {
    LK_IDLE = 3'd0,
    LK_K1   = 3'd1,
    LK_K0   = 3'd2,
    LK_K1B  = 3'd3,
    LK_RD0  = 3'd4
  } gpl_lk_e;

  localparam int unsigned DATA_W   = 32;
  localparam int unsigned FIELD_W  = 4;
  localparam logic [3:0]  FIELD_RST = 4'h4;
endpackage

// File: rtl/gpl_sync.sv
module gpl_sync #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/gpl_lock_seq.sv
module gpl_lock_seq
  import gpl_pkg::*;
#(
  parameter int unsigned NPIN = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_hit,
  input  logic            rd_hit,
  input  logic            wkey,
  input  logic [NPIN-1:0] wmask,
  output logic [NPIN-1:0] mask_q,
  output logic            locked_q,
  output logic            key_rd
);
  gpl_lk_e st;
  logic    same;

  assign same   = (wmask == mask_q);
  assign key_rd = locked_q | (st == LK_RD0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= LK_IDLE;
      mask_q   <= '0;
      locked_q <= 1'b0;
    end else if (!locked_q) begin
      if (wr_hit) begin
        mask_q <= wmask;
        case (st)
          LK_IDLE: st <= wkey ? LK_K1 : LK_IDLE;
          LK_K1:   st <= (!wkey && same) ? LK_K0 : LK_IDLE;
          LK_K0:   st <= (wkey && same) ? LK_K1B : LK_IDLE;
          default: st <= LK_IDLE;
        endcase
      end else if (rd_hit) begin
        case (st)
          LK_K1B: st <= LK_RD0;
          LK_RD0: begin
            st       <= LK_IDLE;
            locked_q <= 1'b1;
          end
          default: st <= LK_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/gpl_cfg_bank.sv
module gpl_cfg_bank
  import gpl_pkg::*;
#(
  parameter int unsigned NPIN = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_lo,
  input  logic                    wr_hi,
  input  logic                    wr_boost,
  input  logic [DATA_W-1:0]       wdata,
  input  logic [NPIN-1:0]         frozen,
  output logic [NPIN*FIELD_W-1:0] cfg_q,
  output logic [NPIN-1:0]         boost_q
);
  localparam int unsigned PER_REG = DATA_W / FIELD_W;

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    localparam int unsigned SLOT = i % PER_REG;
    logic wr_me;
    assign wr_me = ((i / PER_REG) == 0) ? wr_lo : wr_hi;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q[i*FIELD_W +: FIELD_W] <= FIELD_RST;
        boost_q[i]                  <= 1'b0;
      end else if (!frozen[i]) begin
        if (wr_me)    cfg_q[i*FIELD_W +: FIELD_W] <= wdata[SLOT*FIELD_W +: FIELD_W];
        if (wr_boost) boost_q[i]                  <= wdata[i];
      end
    end
  end
endmodule

// File: rtl/gpl_pad_drv.sv
module gpl_pad_drv
  import gpl_pkg::*;
#(
  parameter int unsigned NPIN = 16
) (
  input  logic [NPIN*FIELD_W-1:0] cfg,
  input  logic [NPIN-1:0]         odat,
  output logic [NPIN-1:0]         pad_out,
  output logic [NPIN-1:0]         pad_oe,
  output logic [NPIN-1:0]         pad_pu,
  output logic [NPIN-1:0]         pad_pd
);
  for (genvar i = 0; i < NPIN; i++) begin : g_drv
    logic [3:0] f;
    logic       is_out, is_od, is_pull;
    assign f       = cfg[i*FIELD_W +: FIELD_W];
    assign is_out  = |f[1:0];
    assign is_od   = f[2];
    assign is_pull = !is_out && (f[3:2] == 2'b10);

    assign pad_out[i] = is_out && !is_od && odat[i];
    assign pad_oe[i]  = is_out && (!is_od || !odat[i]);
    assign pad_pu[i]  = is_pull && odat[i];
    assign pad_pd[i]  = is_pull && !odat[i];
  end
endmodule

// File: rtl/gpio_lockport.sv
module gpio_lockport
  import gpl_pkg::*;
#(
  parameter int unsigned NPIN = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NPIN-1:0]   pad_in,
  output logic [NPIN-1:0]   pad_out,
  output logic [NPIN-1:0]   pad_oe,
  output logic [NPIN-1:0]   pad_pu,
  output logic [NPIN-1:0]   pad_pd
);
  localparam int unsigned CFG_W = NPIN * FIELD_W;
  localparam int unsigned PAD_W = DATA_W - NPIN;

  gpl_addr_e            adr;
  logic [NPIN-1:0]      odat_q, in_q, boost_q, lock_mask, frozen;
  logic [CFG_W-1:0]     cfg_q;
  logic                 locked, key_rd;
  logic [DATA_W-1:0]    rd_mux;

  assign adr = gpl_addr_e'(bus_addr);

  gpl_sync #(.W(NPIN)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(in_q)
  );

  gpl_lock_seq #(.NPIN(NPIN)) u_lock (
    .clk(clk), .rst_n(rst_n),
    .wr_hit(bus_wr && adr == ADR_LOCK),
    .rd_hit(bus_rd && adr == ADR_LOCK),
    .wkey(bus_wdata[NPIN]),
    .wmask(bus_wdata[NPIN-1:0]),
    .mask_q(lock_mask), .locked_q(locked), .key_rd(key_rd)
  );

  assign frozen = locked ? lock_mask : '0;

  gpl_cfg_bank #(.NPIN(NPIN)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .wr_lo(bus_wr && adr == ADR_CFGL),
    .wr_hi(bus_wr && adr == ADR_CFGH),
    .wr_boost(bus_wr && adr == ADR_BOOST),
    .wdata(bus_wdata), .frozen(frozen),
    .cfg_q(cfg_q), .boost_q(boost_q)
  );

  gpl_pad_drv #(.NPIN(NPIN)) u_drv (
    .cfg(cfg_q), .odat(odat_q),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      odat_q <= '0;
    end else if (bus_wr) begin
      case (adr)
        ADR_OUT: odat_q <= bus_wdata[NPIN-1:0];
        ADR_SET: odat_q <= odat_q | bus_wdata[NPIN-1:0];
        ADR_CLR: odat_q <= odat_q & ~bus_wdata[NPIN-1:0];
        default: odat_q <= odat_q;
      endcase
    end
  end

  always_comb begin
    case (adr)
      ADR_CFGL:  rd_mux = cfg_q[0 +: DATA_W];
      ADR_CFGH:  rd_mux = cfg_q[DATA_W +: DATA_W];
      ADR_IN:    rd_mux = {{PAD_W{1'b0}}, in_q};
      ADR_OUT:   rd_mux = {{PAD_W{1'b0}}, odat_q};
      ADR_BOOST: rd_mux = {{PAD_W{1'b0}}, boost_q};
      ADR_LOCK:  rd_mux = {{(PAD_W-1){1'b0}}, key_rd, lock_mask};
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

module gpio_lockport_chk
  import gpl_pkg::*;
#(
  parameter int unsigned NPIN = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [2:0]              bus_addr,
  input logic                    bus_wr,
  input logic [NPIN-1:0]         wlo,
  input logic [NPIN-1:0]         pad_in,
  input logic [NPIN-1:0]         pad_oe,
  input logic [NPIN-1:0]         pad_pu,
  input logic [NPIN-1:0]         pad_pd,
  input logic [NPIN-1:0]         odat,
  input logic [NPIN*FIELD_W-1:0] cfg,
  input logic [NPIN-1:0]         boost,
  input logic [NPIN-1:0]         lock_mask,
  input logic                    locked,
  input logic [NPIN-1:0]         in_stat
);
  logic [NPIN*FIELD_W-1:0] lk4;
  logic [1:0]              warm;

  for (genvar i = 0; i < NPIN; i++) begin : g_exp
    assign lk4[i*FIELD_W +: FIELD_W] = {FIELD_W{lock_mask[i]}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             warm <= 2'd0;
    else if (warm != 2'd3)  warm <= warm + 2'd1;
  end

  AST_SET_MERGES: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADR_SET) |=> odat == ($past(odat) | $past(wlo))); // R3
  AST_CLR_REMOVES: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADR_CLR) |=> odat == ($past(odat) & ~$past(wlo))); // R3
  AST_PULL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_pu & pad_pd) == '0) && (((pad_pu | pad_pd) & pad_oe) == '0)); // R6
  AST_SYNC_TWO_FLOP: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd3) |-> in_stat == $past(pad_in, 2)); // R7
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked && $stable(lock_mask)); // R11
  AST_LOCKED_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> ((cfg & lk4) == ($past(cfg) & lk4))
               && ((boost & lock_mask) == ($past(boost) & lock_mask))); // R9
endmodule

bind gpio_lockport gpio_lockport_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .wlo(bus_wdata[15:0]), .pad_in(pad_in), .pad_oe(pad_oe),
  .pad_pu(pad_pu), .pad_pd(pad_pd), .odat(odat_q), .cfg(cfg_q),
  .boost(boost_q), .lock_mask(lock_mask), .locked(locked), .in_stat(in_q)
);

// File: tb/gpio_lockport_bench.sv
`timescale 1ns/1ps
module gpio_lockport_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic [15:0] pad_in = '0;
  logic [15:0] pad_out, pad_oe, pad_pu, pad_pd;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  gpio_lockport u_gpio_lockport (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_pu(pad_pu), .pad_pd(pad_pd)
  );

  // fields: [71:68] req, [67] 1=read-check, [66:64] addr, [63:32] wdata, [31:0] expect
  localparam int TBL_N = 14;
  localparam logic [71:0] TBL [TBL_N] = '{
    {4'd4, 1'b0, 3'd3, 32'h0000A5A5, 32'h0},        // R4 write OUT
    {4'd4, 1'b1, 3'd3, 32'h0,        32'h0000A5A5}, // R4 read OUT
    {4'd3, 1'b0, 3'd4, 32'h00000F00, 32'h0},        // R3 SET
    {4'd3, 1'b1, 3'd3, 32'h0,        32'h0000AFA5}, // R3
    {4'd3, 1'b0, 3'd5, 32'h000000A5, 32'h0},        // R3 CLR
    {4'd3, 1'b1, 3'd3, 32'h0,        32'h0000AF00}, // R3
    {4'd4, 1'b1, 3'd4, 32'h0,        32'h0},        // R4 SET reads 0
    {4'd4, 1'b1, 3'd5, 32'h0,        32'h0},        // R4 CLR reads 0
    {4'd2, 1'b0, 3'd0, 32'h44448851, 32'h0},        // R2 CFG_LO
    {4'd2, 1'b1, 3'd0, 32'h0,        32'h44448851}, // R2
    {4'd2, 1'b0, 3'd1, 32'h12345678, 32'h0},        // R2 CFG_HI
    {4'd2, 1'b1, 3'd1, 32'h0,        32'h12345678}, // R2
    {4'd2, 1'b0, 3'd6, 32'hFFFF00FF, 32'h0},        // R2 boost
    {4'd2, 1'b1, 3'd6, 32'h0,        32'h000000FF}  // R2
  };

  task automatic check(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [31:0] r, r1, r2, r3;
    do_reset();

    for (int k = 0; k < TBL_N; k++) begin
      logic [71:0] e;
      e = TBL[k];
      if (e[67]) begin
        rd(e[66:64], r);
        check(int'(e[71:68]), "table read", r, e[31:0]);
      end else begin
        wr(e[66:64], e[63:32]);
      end
    end

    // R1 reset state
    do_reset();
    rd(3'd0, r); check(1, "reset CFG_LO", r, 32'h44444444); // R1
    rd(3'd1, r); check(1, "reset CFG_HI", r, 32'h44444444); // R1
    rd(3'd3, r); check(1, "reset OUT", r, 32'h0);          // R1
    rd(3'd6, r); check(1, "reset boost", r, 32'h0);        // R1
    rd(3'd7, r); check(1, "reset lock", r, 32'h0);         // R1
    check(1, "reset pads", {pad_oe, pad_pu | pad_pd}, 32'h0); // R1

    // R5/R6 pad drive: pin0 push-pull, pin1 open-drain, pins2,3 pulled
    wr(3'd0, 32'h44448851);
    wr(3'd3, 32'h00000005);
    check(5, "oe pp+od", {16'h0, pad_oe}, 32'h0003);  // R5
    check(5, "out pp+od", {16'h0, pad_out}, 32'h0001); // R5
    check(6, "pull up", {16'h0, pad_pu}, 32'h0004);    // R6
    check(6, "pull down", {16'h0, pad_pd}, 32'h0008);  // R6
    wr(3'd4, 32'h00000002);
    check(5, "od released", {16'h0, pad_oe}, 32'h0001); // R5

    // R7 synchronizer latency
    pad_in = 16'hBEEF;
    rd(3'd2, r1); rd(3'd2, r2); rd(3'd2, r3);
    check(7, "in first", r1, 32'h0);      // R7
    check(7, "in second", r2, 32'h0);     // R7
    check(7, "in third", r3, 32'h0000BEEF); // R7

    // R8/R12 successful lock of pins 0,1 with other traffic interleaved
    wr(3'd7, 32'h00010003);
    wr(3'd3, 32'h000000F0);               // R12 interleaved write
    wr(3'd7, 32'h00000003);
    rd(3'd0, r);                          // R12 interleaved read
    wr(3'd7, 32'h00010003);
    rd(3'd7, r1); rd(3'd7, r2);
    check(8, "lock read 1", r1, 32'h00000003); // R8
    check(8, "lock read 2", r2, 32'h00010003); // R8

    // R9 frozen fields
    wr(3'd0, 32'hFFFFFFFF);
    rd(3'd0, r); check(9, "locked CFG_LO", r, 32'hFFFFFF51); // R9
    wr(3'd6, 32'h0000FFFF);
    rd(3'd6, r); check(9, "locked boost", r, 32'h0000FFFC);  // R9
    wr(3'd3, 32'h00000003);
    rd(3'd3, r); check(9, "OUT writable", r, 32'h00000003);  // R9
    wr(3'd1, 32'h0);
    rd(3'd1, r); check(9, "CFG_HI writable", r, 32'h0);      // R9

    // R11 relock attempt changes nothing
    wr(3'd7, 32'h0001FFFF); wr(3'd7, 32'h0000FFFF); wr(3'd7, 32'h0001FFFF);
    rd(3'd7, r1); rd(3'd7, r2);
    check(11, "relock", r2, 32'h00010003); // R11

    // R10 mask changed partway
    do_reset();
    wr(3'd7, 32'h00010005); wr(3'd7, 32'h00000006); wr(3'd7, 32'h00010006);
    rd(3'd7, r1); rd(3'd7, r2);
    check(10, "mask change key", r2, 32'h00000006); // R10
    wr(3'd0, 32'h0);
    rd(3'd0, r); check(10, "mask change cfg", r, 32'h0); // R10

    // R10 write where a read belongs
    wr(3'd7, 32'h00010005); wr(3'd7, 32'h00000005); wr(3'd7, 32'h00010005);
    wr(3'd7, 32'h00010005);
    rd(3'd7, r1); rd(3'd7, r2);
    check(10, "order break key", r2, 32'h00000005); // R10
    wr(3'd6, 32'h0000FFFF);
    rd(3'd6, r); check(10, "order break boost", r, 32'h0000FFFF); // R10

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule